// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame to evict when memory is full, using the second-chance clock policy. It holds one reference flag and one lock flag for every frame. A circular hand points at the next frame to inspect. The reference port marks a frame as recently used, and the lock port pins or unpins a frame.

When a victim is requested, the hand sweeps forward one frame per cycle. Locked frames are stepped over and left as they are. An unlocked frame whose reference flag is set loses that flag and is passed. The first unlocked frame found with its flag already clear becomes the victim. If two full revolutions yield nothing, the block reports that no victim exists.

The result is held on the outputs until the requester acknowledges it. The hand keeps its position between requests, so each new sweep resumes just past the previous victim.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `done` and `no_victim` are 0, every reference and lock flag is clear, and the hand points at frame 0.
- R2: A pulse on `ref_valid` sets the reference flag of frame `ref_idx`. A referenced, unlocked frame is passed over on the first visit of a sweep.
- R3: Each unlocked frame that a sweep passes with its reference flag set has that flag cleared. On a later visit, without a new reference, the frame can be chosen.
- R4: The victim is the first frame, counting from the hand in increasing index order with wrap from NFRAMES-1 to 0, that is unlocked and has a clear reference flag.
- R5: A pulse on `lock_valid` with `lock_set`=1 locks frame `lock_idx`, and with `lock_set`=0 unlocks it. A locked frame is never returned as a victim.
- R6: After a victim is chosen, the hand rests on the frame just past it, and the next sweep starts there.
- R7: If the sweep examines 2*NFRAMES frames without finding a victim, it ends with `done`=1, `no_victim`=1 and `victim_idx`=0. `done` rises 2*NFRAMES cycles after the request is accepted, and the hand is back at its starting frame.
- R8: If a reference to a frame arrives in the same cycle that the sweep clears that frame's flag, the flag ends at 1.
- R9: `done`, `victim_idx` and `no_victim` stay constant until `ack` is sampled high while `done` is 1. A `req` is accepted only while idle and is otherwise ignored.
- R10: `done` rises on the k-th rising edge after the edge that accepted `req`, where k is the number of frames examined including the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference strobe |
| ref_idx | input | IDX_W | Frame that was referenced |
| lock_valid | input | 1 | Lock update strobe |
| lock_idx | input | IDX_W | Frame whose lock flag is written |
| lock_set | input | 1 | 1 locks the frame, 0 unlocks it |
| req | input | 1 | Victim request, accepted when idle |
| ack | input | 1 | Acknowledge of a held result |
| done | output | 1 | Result valid |
| victim_idx | output | IDX_W | Chosen frame, 0 when none |
| no_victim | output | 1 | Sweep found no replaceable frame |

## Verification
A reference and a sweep clear can land on the same frame in the same cycle. To provoke this, the bench locks frames 0 to 2, references every frame, and starts a sweep. It then pulses a reference to frame 3 on exactly the edge where the hand inspects frame 3, four edges after acceptance. If the reference wins, frame 3 survives into the second revolution and the victim is frame 4. If the clear wins, the victim is frame 3, so the returned index decides the outcome.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

    typedef enum logic [1:0] {
        SWEEP_IDLE = 2'd0,
        SWEEP_RUN  = 2'd1,
        SWEEP_HOLD = 2'd2
    } sweep_state_e;

    // step a circular position forward by one over n slots
    function automatic int unsigned step_wrap(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/clock_frame_flags.sv
module clock_frame_flags #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_valid,
    input  logic [IDX_W-1:0]   ref_idx,
    input  logic               lock_valid,
    input  logic [IDX_W-1:0]   lock_idx,
    input  logic               lock_set,
    input  logic               clr_valid,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NFRAMES-1:0] ref_vec,
    output logic [NFRAMES-1:0] lock_vec
);

    for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
        logic ref_hit;
        logic clr_hit;
        logic lock_hit;

        assign ref_hit  = ref_valid  && (ref_idx  == IDX_W'(g));
        assign clr_hit  = clr_valid  && (clr_idx  == IDX_W'(g));
        assign lock_hit = lock_valid && (lock_idx == IDX_W'(g));

        // a new reference outranks the sweep's clear
        always_ff @(posedge clk) begin
            if (rst) begin
                ref_vec[g] <= 1'b0;
            end else if (ref_hit) begin
                ref_vec[g] <= 1'b1;
            end else if (clr_hit) begin
                ref_vec[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lock_vec[g] <= 1'b0;
            end else if (lock_hit) begin
                lock_vec[g] <= lock_set;
            end
        end
    end

endmodule

// File: rtl/clock_sweep_ctrl.sv
module clock_sweep_ctrl
    import clock_sel_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               ack,
    input  logic [NFRAMES-1:0] ref_vec,
    input  logic [NFRAMES-1:0] lock_vec,
    output logic               clr_valid,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               done,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               no_victim
);

    localparam int LIMIT = 2 * NFRAMES;
    localparam int CNT_W = $clog2(LIMIT) + 1;

    sweep_state_e     state_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] hand_nx;
    logic [CNT_W-1:0] seen_q;
    logic [IDX_W-1:0] victim_q;
    logic             none_q;
    logic             cur_ref;
    logic             cur_lock;
    logic             pick;
    logic             last_look;

    always_comb begin
        cur_ref   = ref_vec[hand_q];
        cur_lock  = lock_vec[hand_q];
        hand_nx   = IDX_W'(step_wrap(int'(hand_q), NFRAMES));
        pick      = (state_q == SWEEP_RUN) && !cur_lock && !cur_ref;
        clr_valid = (state_q == SWEEP_RUN) && !cur_lock && cur_ref;
        clr_idx   = hand_q;
        last_look = (seen_q == CNT_W'(LIMIT - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SWEEP_IDLE;
            hand_q   <= '0;
            seen_q   <= '0;
            victim_q <= '0;
            none_q   <= 1'b0;
        end else begin
            case (state_q)
                SWEEP_IDLE: begin
                    if (req) begin
                        state_q <= SWEEP_RUN;
                        seen_q  <= '0;
                    end
                end
                SWEEP_RUN: begin
                    hand_q <= hand_nx;
                    if (pick) begin
                        victim_q <= hand_q;
                        none_q   <= 1'b0;
                        state_q  <= SWEEP_HOLD;
                    end else if (last_look) begin
                        victim_q <= '0;
                        none_q   <= 1'b1;
                        state_q  <= SWEEP_HOLD;
                    end else begin
                        seen_q <= seen_q + 1'b1;
                    end
                end
                SWEEP_HOLD: begin
                    if (ack) begin
                        state_q <= SWEEP_IDLE;
                    end
                end
                default: state_q <= SWEEP_IDLE;
            endcase
        end
    end

    assign done       = (state_q == SWEEP_HOLD);
    assign victim_idx = victim_q;
    assign no_victim  = none_q;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             lock_valid,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic             lock_set,
    input  logic             req,
    input  logic             ack,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             no_victim
);

    logic [NFRAMES-1:0] ref_vec;
    logic [NFRAMES-1:0] lock_vec;
    logic               clr_valid;
    logic [IDX_W-1:0]   clr_idx;

    clock_frame_flags #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .ref_valid (ref_valid),
        .ref_idx   (ref_idx),
        .lock_valid(lock_valid),
        .lock_idx  (lock_idx),
        .lock_set  (lock_set),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .ref_vec   (ref_vec),
        .lock_vec  (lock_vec)
    );

    clock_sweep_ctrl #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ack       (ack),
        .ref_vec   (ref_vec),
        .lock_vec  (lock_vec),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .done      (done),
        .victim_idx(victim_idx),
        .no_victim (no_victim)
    );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_valid,
    input logic [IDX_W-1:0]   ref_idx,
    input logic               req,
    input logic               ack,
    input logic               done,
    input logic [IDX_W-1:0]   victim_idx,
    input logic               no_victim,
    input logic [NFRAMES-1:0] ref_vec,
    input logic [NFRAMES-1:0] lock_vec
);

    logic [NFRAMES-1:0] lock_d;
    always_ff @(posedge clk) lock_d <= lock_vec;

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !ack |=> done && $stable(victim_idx) && $stable(no_victim));

    // R9
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        done && req && !ack |=> done);

    // R2
    ref_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> ref_vec[$past(ref_idx)]);

    // R5
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) && !no_victim |-> !lock_d[victim_idx]);

    // R7
    none_zero_idx_chk: assert property (@(posedge clk) disable iff (rst)
        done && no_victim |-> victim_idx == '0);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_valid (ref_valid),
    .ref_idx   (ref_idx),
    .req       (req),
    .ack       (ack),
    .done      (done),
    .victim_idx(victim_idx),
    .no_victim (no_victim),
    .ref_vec   (ref_vec),
    .lock_vec  (lock_vec)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          lock_valid = 1'b0;
    logic [IW-1:0] lock_idx = '0;
    logic          lock_set = 1'b0;
    logic          req = 1'b0;
    logic          ack = 1'b0;
    logic          done;
    logic [IW-1:0] victim_idx;
    logic          no_victim;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    clock_victim_sel #(.NFRAMES(N)) dut (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_idx(ref_idx),
        .lock_valid(lock_valid), .lock_idx(lock_idx), .lock_set(lock_set),
        .req(req), .ack(ack),
        .done(done), .victim_idx(victim_idx), .no_victim(no_victim)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic touch(input int f);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_idx   = IW'(f);
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic set_lock(input int f, input bit v);
        @(negedge clk);
        lock_valid = 1'b1;
        lock_idx   = IW'(f);
        lock_set   = v;
        @(posedge clk);
        @(negedge clk);
        lock_valid = 1'b0;
    endtask

    // waits for done after acceptance, counts edges, then acknowledges
    task automatic wait_result(output int vic, output int none, output int lat);
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        vic  = int'(victim_idx);
        none = int'(no_victim);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic request(output int vic, output int none, output int lat);
        @(negedge clk);
        req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        wait_result(vic, none, lat);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 done after reset", int'(done), 0);
        chk("R1 no_victim after reset", int'(no_victim), 0);
    endtask

    task automatic t_fresh();
        int v, e, l;
        do_reset();
        request(v, e, l);
        chk("R1 hand at 0, victim", v, 0);
        chk("R10 latency one frame", l, 1);
        chk("R4 found flag", e, 0);
        chk("R9 done drops after ack", int'(done), 0);
        request(v, e, l);
        chk("R6 resumes past victim", v, 1);
    endtask

    task automatic t_refs();
        int v, e, l;
        do_reset();
        touch(0);
        touch(1);
        request(v, e, l);
        chk("R2 referenced frames skipped", v, 2);
        chk("R10 latency three frames", l, 3);
        request(v, e, l);
        chk("R6 next victim", v, 3);
        for (int f = 4; f < N; f++) touch(f);
        request(v, e, l);
        chk("R3 cleared frame 0 chosen after wrap", v, 0);
        chk("R10 latency five frames", l, 5);
    endtask

    task automatic t_locks();
        int v, e, l;
        do_reset();
        for (int f = 0; f < N; f++) if (f != 5) set_lock(f, 1'b1);
        request(v, e, l);
        chk("R5 only unlocked frame", v, 5);
        set_lock(2, 1'b0);
        request(v, e, l);
        chk("R5 unlocked frame selectable", v, 2);
        chk("R4 wrap order latency", l, 5);
    endtask

    task automatic t_all_locked();
        int v, e, l;
        do_reset();
        for (int f = 0; f < N; f++) set_lock(f, 1'b1);
        request(v, e, l);
        chk("R7 no_victim", e, 1);
        chk("R7 index zero", v, 0);
        chk("R7 latency two revolutions", l, 2 * N);
        set_lock(0, 1'b0);
        request(v, e, l);
        chk("R7 hand back at start", v, 0);
        chk("R7 flag clear on success", e, 0);
    endtask

    task automatic t_collide();
        int v, e, l;
        do_reset();
        for (int f = 0; f < 3; f++) set_lock(f, 1'b1);
        for (int f = 0; f < N; f++) touch(f);
        @(negedge clk);
        req = 1'b1;
        @(posedge clk);            // accepting edge
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(posedge clk); // frames 0..2 inspected
        @(negedge clk);
        ref_valid = 1'b1;
        ref_idx   = IW'(3);
        @(posedge clk);            // frame 3 inspected and referenced
        @(negedge clk);
        ref_valid = 1'b0;
        wait_result(v, e, l);
        chk("R8 reference beats clear", v, 4);
    endtask

    task automatic t_hold();
        int v, e, l, v0;
        do_reset();
        @(negedge clk);
        req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 not done on accept edge", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        v0 = int'(victim_idx);
        chk("R9 done raised", int'(done), 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 done held", int'(done), 1);
        chk("R9 victim stable", int'(victim_idx), v0);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        req = 1'b0;
        chk("R9 released by ack", int'(done), 0);
        request(v, e, l);
        chk("R9 busy requests ignored", v, 1);
    endtask

    initial begin
        t_reset();
        t_fresh();
        t_refs();
        t_locks();
        t_all_locked();
        t_collide();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule